// File: doc/BRIEF.md
# Descrambler Seed Loader

This block takes a code word from a two-wire serial link and supplies the 9-bit starting value for a descrambling sequence generator. The link has a code-word clock and a code-word data line. Both are asynchronous to the system clock. The block synchronises both lines and detects falling edges of the code-word clock. It counts those edges during each frame and shifts the data bit in on each edge. At the next frame-start strobe it decides between the captured word and the all-ones default. It then presents the chosen value together with a one-cycle load strobe.

While the frame ID flag is high, the block ignores code-word edges. During that period it treats the two link pins as language-select levels. It latches those levels when the flag falls.

The edge count per frame is tracked by a state machine with four states:
- `CW_SHORT`: fewer than 8 edges so far, with a small sub-counter.
- `CW_EIGHT`: exactly 8 edges.
- `CW_NINE`: exactly 9 edges.
- `CW_OVER`: 10 or more edges.

Its transitions are:
- `CW_SHORT`→`CW_EIGHT` on the 8th counted edge.
- `CW_EIGHT`→`CW_NINE` on the next edge.
- `CW_NINE`→`CW_OVER` on the next edge.
- `CW_OVER`→`CW_OVER` on further edges.
- Any state→`CW_SHORT` on frame start. The sub-counter is loaded with 1 if an edge arrives in that same cycle, otherwise with 0.

Top module: `seed_loader`

## Requirements
- R1: After reset, `seed` is 9'h1FF, `seed_load` is 0 and `lang_sel` is 2'b00.
- R2: `seed_load` is high for exactly the one cycle after each cycle in which `frame_start` is high. `seed` takes its new value in that same cycle and does not change in any other cycle.
- R3: If 7 or fewer counted code-word clock falling edges occurred since the previous frame start, the next load gives 9'h1FF.
- R4: `cw_dat` is sampled on each counted falling edge of `cw_clk`. The bits shift in from bit 0 toward bit 8, so earlier bits end up at higher positions.
- R5: With exactly 8 counted edges, the loaded seed is {bit 0 of the shift register before the frame, the 8 new bits with the first received at bit 7}.
- R6: With exactly 9 counted edges, the loaded seed is the 9 received bits, with the first received at bit 8.
- R7: With 10 or more counted edges, only the first 9 bits of the frame are kept. The seed equals the R6 value for those 9 bits.
- R8: Falling edges of `cw_clk` that occur while `fid` is high are neither counted nor shifted.
- R9: When `fid` falls, `lang_sel[1]` takes the level on `cw_clk` and `lang_sel[0]` takes the level on `cw_dat`. `lang_sel` holds at all other times.
- R10: The edge count restarts at every frame start. A word captured in one frame is used only at the end of that frame, and a following frame with no edges loads 9'h1FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe marking a frame boundary |
| fid | input | 1 | Frame ID flag; high during the alignment word |
| cw_clk | input | 1 | Asynchronous code-word clock (language bit 1 while `fid` is high) |
| cw_dat | input | 1 | Asynchronous code-word data (language bit 0 while `fid` is high) |
| seed | output | SEED_W | Preset value for the sequence generator |
| seed_load | output | 1 | Strobe, high when `seed` has just been updated |
| lang_sel | output | 2 | Latched language-select levels |

## Verification
The bench builds the block with its default `SEED_W = 9` and a two-stage synchroniser. At this size every edge-count class can be swept in full: 0 to 12 edges, under several data patterns. That sweep reaches every state and every transition of the count machine. It also covers the carry-over of an old bit in the 8-edge case and the saturation beyond 10 edges. All four language-select codes are also swept, with edges injected while `fid` is high. Expected seeds come from an arithmetic shift-and-count model in the bench.

// File: rtl/seed_pkg.sv
package seed_pkg;
    typedef enum logic [1:0] {
        CW_SHORT = 2'd0,
        CW_EIGHT = 2'd1,
        CW_NINE  = 2'd2,
        CW_OVER  = 2'd3
    } cw_state_e;
endpackage

// File: rtl/cw_sync.sv
module cw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain[g] <= RST_VAL;
                else if (g == 0)
                    chain[g] <= d;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cw_shift.sv
module cw_shift #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word <= '1;
        else if (shift_en)
            word <= {word[W-2:0], bit_in};
    end
endmodule

// File: rtl/seed_fsm.sv
module seed_fsm
    import seed_pkg::*;
#(
    parameter int W = 9
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_start,
    input  logic      fid,
    input  logic      cw_fall,
    output logic      shift_en,
    output logic      seed_take,
    output cw_state_e state
);
    localparam int CW = $clog2(W - 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(W - 2);

    cw_state_e     state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          edge_ok;

    assign edge_ok = cw_fall & ~fid;

    always_comb begin
        state_d = state;
        cnt_d   = cnt_q;
        if (frame_start) begin
            state_d = CW_SHORT;
            cnt_d   = edge_ok ? CW'(1) : '0;
        end else if (edge_ok) begin
            unique case (state)
                CW_SHORT: begin
                    if (cnt_q == LAST_SHORT) begin
                        state_d = CW_EIGHT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                CW_EIGHT: state_d = CW_NINE;
                CW_NINE:  state_d = CW_OVER;
                CW_OVER:  state_d = CW_OVER;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CW_SHORT;
            cnt_q <= '0;
        end else begin
            state <= state_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        shift_en  = 1'b0;
        seed_take = 1'b0;
        unique case (state)
            CW_SHORT: shift_en = edge_ok;
            CW_EIGHT: begin
                shift_en  = edge_ok;
                seed_take = 1'b1;
            end
            CW_NINE: begin
                shift_en  = edge_ok & frame_start;
                seed_take = 1'b1;
            end
            CW_OVER: begin
                shift_en  = edge_ok & frame_start;
                seed_take = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/seed_loader.sv
module seed_loader #(
    parameter int SEED_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              fid,
    input  logic              cw_clk,
    input  logic              cw_dat,
    output logic [SEED_W-1:0] seed,
    output logic              seed_load,
    output logic [1:0]        lang_sel
);
    import seed_pkg::*;

    logic              clk_s, dat_s, clk_s_q, fid_q;
    logic              cw_fall, shift_en, seed_take;
    logic [SEED_W-1:0] sreg;
    cw_state_e         fsm_state;

    cw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d(cw_clk), .q(clk_s)
    );
    cw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d(cw_dat), .q(dat_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_s_q <= 1'b1;
            fid_q   <= 1'b0;
        end else begin
            clk_s_q <= clk_s;
            fid_q   <= fid;
        end
    end

    assign cw_fall = clk_s_q & ~clk_s;

    seed_fsm #(.W(SEED_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fid(fid),
        .cw_fall(cw_fall), .shift_en(shift_en), .seed_take(seed_take),
        .state(fsm_state)
    );

    cw_shift #(.W(SEED_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(dat_s),
        .word(sreg)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed      <= '1;
            seed_load <= 1'b0;
            lang_sel  <= 2'b00;
        end else begin
            seed_load <= frame_start;
            if (frame_start)
                seed <= seed_take ? sreg : '1;
            if (fid_q && !fid)
                lang_sel <= {clk_s, dat_s};
        end
    end
endmodule

// File: rtl/seed_chk.sv
module seed_chk
    import seed_pkg::*;
#(
    parameter int W = 9
) (
    input logic         clk,
    input logic         rst_n,
    input logic         frame_start,
    input logic         fid,
    input logic [W-1:0] seed,
    input logic         seed_load,
    input logic [1:0]   lang_sel,
    input cw_state_e    state
);
    AST_LOAD_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> seed_load);                                   // R2
    AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> !seed_load);                                 // R2
    AST_SEED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !seed_load |-> $stable(seed));                                // R2
    AST_SHORT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && state == CW_SHORT) |=> (seed == '1));         // R3
    AST_FID_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (fid && !frame_start) |=> $stable(state));                    // R8
    AST_LANG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(fid) |=> $stable(lang_sel));                           // R9
endmodule

bind seed_loader seed_chk #(.W(SEED_W)) u_seed_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fid(fid),
    .seed(seed), .seed_load(seed_load), .lang_sel(lang_sel),
    .state(fsm_state)
);

// File: tb/test_seed_loader.sv
module test_seed_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       fid = 1'b0;
    logic       cw_clk = 1'b1;
    logic       cw_dat = 1'b0;
    logic [8:0] seed;
    logic       seed_load;
    logic [1:0] lang_sel;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [8:0] m_sreg = 9'h1FF;
    int         m_cnt = 0;

    always #5 clk = ~clk;

    seed_loader i_seed_loader (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fid(fid),
        .cw_clk(cw_clk), .cw_dat(cw_dat), .seed(seed),
        .seed_load(seed_load), .lang_sel(lang_sel)
    );

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cw_edge(logic b);
        @(negedge clk);
        cw_dat = b;
        repeat (3) @(negedge clk);
        cw_clk = 1'b0;
        repeat (4) @(negedge clk);
        cw_clk = 1'b1;
        repeat (4) @(negedge clk);
        if (!fid) begin
            if (m_cnt < 9) m_sreg = {m_sreg[7:0], b};
            if (m_cnt < 10) m_cnt++;
        end
    endtask

    task automatic frame(string req, logic [8:0] hand, bit use_hand);
        logic [8:0] exp;
        exp = (m_cnt >= 8) ? m_sreg : 9'h1FF;
        if (use_hand) exp = hand;
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check({req, " load strobe (R2)"}, {8'd0, seed_load}, 9'd1);
        check(req, seed, exp);
        @(negedge clk);
        check("R2 strobe drop", {8'd0, seed_load}, 9'd0);
        check("R2 seed held", seed, exp);
        m_cnt = 0;
    endtask

    task automatic send_word(logic [8:0] w, int n);
        for (int i = 0; i < n; i++) cw_edge(w[8 - (i % 9)]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 seed", seed, 9'h1FF);
        check("R1 load", {8'd0, seed_load}, 9'd0);
        check("R1 lang", {7'd0, lang_sel}, 9'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4 R6: nine bits, first received at bit 8
        send_word(9'h1C3, 9);
        frame("R6 nine bits", 9'h1C3, 1'b1);
        // R5: eight bits, old bit 0 (1) lands at bit 8
        send_word({8'h5A, 1'b0}, 8);
        frame("R5 eight bits", 9'h15A, 1'b1);
        // R10: empty frame after captured word
        frame("R10 empty frame", 9'h1FF, 1'b1);
        // R7: twelve edges keep first nine
        send_word(9'h0B6, 9);
        send_word(9'h1FF, 3);
        frame("R7 overflow", 9'h0B6, 1'b1);

        // sweep of edge counts and patterns against the model
        for (int p = 0; p < 3; p++) begin
            for (int n = 0; n <= 12; n++) begin
                logic [8:0] w;
                w = 9'((p * 173 + n * 59 + 37) % 512);
                send_word(w, n);
                if (n <= 7)      frame("R3 sweep", 9'h0, 1'b0);
                else if (n == 8) frame("R5 sweep", 9'h0, 1'b0);
                else if (n == 9) frame("R4 R6 sweep", 9'h0, 1'b0);
                else             frame("R7 sweep", 9'h0, 1'b0);
            end
        end

        // R8: edges during fid are ignored
        send_word({8'hA5, 1'b0}, 8);
        @(negedge clk);
        fid = 1'b1;
        send_word(9'h000, 5);
        @(negedge clk);
        fid = 1'b0;
        frame("R8 fid edges ignored", 9'h0, 1'b0);

        // R9: language select sweep
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            fid = 1'b1;
            cw_clk = v[1];
            cw_dat = v[0];
            repeat (5) @(negedge clk);
            fid = 1'b0;
            repeat (2) @(negedge clk);
            check("R9 lang latch", {7'd0, lang_sel}, 9'(v));
            cw_clk = ~cw_clk;
            cw_dat = ~cw_dat;
            repeat (5) @(negedge clk);
            check("R9 lang hold", {7'd0, lang_sel}, 9'(v));
            cw_clk = 1'b1;
            repeat (5) @(negedge clk);
        end
        frame("R8 R10 no counted edges", 9'h1FF, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule